// File: doc/BRIEF.md
# Bus Error Capture Register with Lock

This block holds the 32-bit error status word of one node on a shared system bus, together with a small configuration word. Bus monitoring logic elsewhere reports each detected fault as a single-cycle pulse on one line of `err_evt`. Each pulse sets the matching sticky status bit. Software reads either register through a plain select/write port. It clears status bits by writing ones, and it watches a level interrupt that covers the status bits it has not masked.

For diagnosis, the configuration word has a lock-on-first-error enable. While that enable is set, the first recorded non-syndrome error moves a two-state lock machine from `LK_OPEN` to `LK_HELD`. From then on, further error pulses are dropped, so software reads a stable snapshot. The four data syndrome bits never trigger the lock. The machine goes back to `LK_OPEN` on the edge where the status word becomes all zero, or on the edge after the enable has been cleared. Two further configuration bits switch off detection of bank lock timeouts and data timeouts at the block's input. Two others keep correctable write and read data errors from raising the interrupt.

Top module: `bus_err_capture`

## Requirements
- R1: After reset the status word and the configuration word both read 0, `irq_o` is low, and the lock machine is in `LK_OPEN`.
- R2: An `err_evt[i]` pulse sets status bit i at the next clock edge when i is in 0..10 or 16..31. Bits 11..15 are not implemented: they always read 0 and pulses on them are ignored.
- R3: A status write (`reg_wr`=1, `reg_addr`=0) clears every status bit written as 1 and leaves bits written as 0 unchanged. If an event and a clear hit the same bit in the same cycle while the register is open, the bit ends set.
- R4: With configuration bit 31 (lock on first error) at 1, an event on any implemented bit outside 20..23 takes `LK_OPEN` to `LK_HELD` at the edge that records it. All events of that same cycle are recorded.
- R5: Events on bits 20..23 (data syndrome 0..3) are recorded but never cause the lock.
- R6: While `LK_HELD` and configuration bit 31 are both active, every error pulse is discarded. Status changes only through software clears.
- R7: `LK_HELD` returns to `LK_OPEN` at the edge where software clears the last set status bit. Later events are recorded again.
- R8: Writing configuration bit 31 to 0 releases the lock. Events presented after that write are recorded.
- R9: Configuration bit 2 set drops bank lock timeout pulses (status bit 3). Configuration bit 3 set drops data timeout pulses (status bit 31). Neither bit then gets set.
- R10: `irq_o` is high while any status bit is set, with two exceptions. Bit 17 (correctable write data) is ignored when configuration bit 0 is 1. Bits 18 and 19 (correctable read data) are ignored when configuration bit 1 is 1.
- R11: The configuration word holds bits 0..3, a node ID in bits 7:4 and bit 31, all writable (`reg_wr`=1, `reg_addr`=1). All other bits read 0.
- R12: `reg_rdata` shows the status word when `reg_addr`=0 and the configuration word when `reg_addr`=1, combinationally from the registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Write strobe for the selected register |
| reg_addr | input | 1 | Register select: 0 status, 1 configuration |
| reg_wdata | input | 32 | Write data (status: ones clear) |
| reg_rdata | output | 32 | Read data of the selected register |
| err_evt | input | 32 | Single-cycle error event pulses, one per status bit |
| irq_o | output | 1 | Level interrupt for unmasked status bits |

## Verification
The bench builds the block with its default 32-bit word and 4-bit node ID field. This puts every implemented status position, the unimplemented gap at bits 11..15, and the full writable configuration mask within reach of single writes and pulses. With those widths, one short sequence can drive the lock machine through both of its exits: a clear of the last bit, and removal of the enable. It also places syndrome-only events, simultaneous lock-causing events and same-cycle clear/set collisions at exact edges.

// File: rtl/errcap_pkg.sv
package errcap_pkg;

    localparam int REG_W      = 32;
    localparam int NODE_W     = 4;

    // status bit positions with special handling
    localparam int ST_LKTO    = 3;
    localparam int ST_CWD     = 17;
    localparam int ST_CRD_A   = 18;
    localparam int ST_CRD_B   = 19;
    localparam int ST_DTO     = 31;

    // implemented status bits and lock-exempt syndrome bits
    localparam logic [REG_W-1:0] ST_IMPL_MASK = 32'hFFFF_07FF;
    localparam logic [REG_W-1:0] ST_SYND_MASK = 32'h00F0_0000;

    // configuration bit positions
    localparam int CF_CWD_IRQ_OFF = 0;
    localparam int CF_CRD_IRQ_OFF = 1;
    localparam int CF_LKTO_OFF    = 2;
    localparam int CF_DTO_OFF     = 3;
    localparam int CF_NODE_LO     = 4;
    localparam int CF_LOFE        = 31;

    typedef enum logic [0:0] {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_state_e;

    typedef struct packed {
        logic              lofe;
        logic [NODE_W-1:0] node_id;
        logic              dto_off;
        logic              lkto_off;
        logic              crd_irq_off;
        logic              cwd_irq_off;
    } cfg_t;

endpackage

// File: rtl/errcap_cfg_reg.sv
module errcap_cfg_reg
    import errcap_pkg::*;
#(
    parameter int W      = REG_W,
    parameter int NID_W  = NODE_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] wdata,
    output cfg_t         cfg_q,
    output logic [W-1:0] cfg_rdata
);
    localparam int NODE_HI = CF_NODE_LO + NID_W - 1;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (wr_en) begin
            cfg_q.cwd_irq_off <= wdata[CF_CWD_IRQ_OFF];
            cfg_q.crd_irq_off <= wdata[CF_CRD_IRQ_OFF];
            cfg_q.lkto_off    <= wdata[CF_LKTO_OFF];
            cfg_q.dto_off     <= wdata[CF_DTO_OFF];
            cfg_q.node_id     <= wdata[NODE_HI:CF_NODE_LO];
            cfg_q.lofe        <= wdata[CF_LOFE];
        end
    end

    always_comb begin
        cfg_rdata                      = '0;
        cfg_rdata[CF_CWD_IRQ_OFF]      = cfg_q.cwd_irq_off;
        cfg_rdata[CF_CRD_IRQ_OFF]      = cfg_q.crd_irq_off;
        cfg_rdata[CF_LKTO_OFF]         = cfg_q.lkto_off;
        cfg_rdata[CF_DTO_OFF]          = cfg_q.dto_off;
        cfg_rdata[NODE_HI:CF_NODE_LO]  = cfg_q.node_id;
        cfg_rdata[CF_LOFE]             = cfg_q.lofe;
    end

    // R11: a write lands in the register on the next edge
    assert_cfg_write_R11: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (cfg_q.lofe == $past(wdata[CF_LOFE])))
        else $error("cfg lofe not written");

endmodule

// File: rtl/errcap_lock_fsm.sv
module errcap_lock_fsm
    import errcap_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         lofe,
    input  logic [W-1:0] set_vec,
    input  logic         next_zero,
    output logic         hold,
    output lock_state_e  state_q
);
    lock_state_e state_d;
    logic        lock_trig;

    assign lock_trig = |(set_vec & ~ST_SYND_MASK);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= LK_OPEN;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            LK_OPEN: if (lofe && lock_trig)     state_d = LK_HELD;
            LK_HELD: if (!lofe || next_zero)    state_d = LK_OPEN;
            default:                            state_d = LK_OPEN;
        endcase
    end

    // outputs
    always_comb begin
        unique case (state_q)
            LK_HELD: hold = lofe;
            default: hold = 1'b0;
        endcase
    end

    assert_lock_on_first_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && lofe && lock_trig) |=> (state_q == LK_HELD))
        else $error("lock not taken");

    assert_synd_no_lock_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_OPEN && (set_vec & ~ST_SYND_MASK) == '0) |=> (state_q == LK_OPEN))
        else $error("syndrome caused lock");

    assert_release_on_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_HELD && next_zero) |=> (state_q == LK_OPEN))
        else $error("lock kept after full clear");

    assert_release_on_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == LK_HELD && !lofe) |=> (state_q == LK_OPEN))
        else $error("lock kept after enable cleared");

endmodule

// File: rtl/errcap_evt_filter.sv
module errcap_evt_filter
    import errcap_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic [W-1:0] evt,
    input  cfg_t         cfg,
    input  logic         hold,
    output logic [W-1:0] set_vec
);
    logic [W-1:0] det_mask;

    always_comb begin
        det_mask          = ST_IMPL_MASK;
        det_mask[ST_LKTO] = ST_IMPL_MASK[ST_LKTO] & ~cfg.lkto_off;
        det_mask[ST_DTO]  = ST_IMPL_MASK[ST_DTO]  & ~cfg.dto_off;
        set_vec           = hold ? '0 : (evt & det_mask);
    end

endmodule

// File: rtl/errcap_status_reg.sv
module errcap_status_reg
    import errcap_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_vec,
    input  logic [W-1:0] clr_vec,
    input  logic         hold,
    output logic [W-1:0] status_q,
    output logic [W-1:0] status_d
);
    always_comb status_d = ((status_q & ~clr_vec) | set_vec) & ST_IMPL_MASK;

    for (genvar b = 0; b < W; b++) begin : g_bit
        if (ST_IMPL_MASK[b]) begin : g_impl
            always_ff @(posedge clk) begin
                if (!rst_n) status_q[b] <= 1'b0;
                else        status_q[b] <= status_d[b];
            end
        end else begin : g_tie
            assign status_q[b] = 1'b0;
        end
    end

    assert_discard_when_locked_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && clr_vec == '0) |=> $stable(status_q))
        else $error("status moved while locked");

    assert_w1c_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_vec != '0) |=> ((status_q & $past(clr_vec & ~set_vec)) == '0))
        else $error("cleared bit survived");

endmodule

// File: rtl/bus_err_capture.sv
module bus_err_capture
    import errcap_pkg::*;
#(
    parameter int W = REG_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         reg_wr,
    input  logic         reg_addr,
    input  logic [W-1:0] reg_wdata,
    output logic [W-1:0] reg_rdata,
    input  logic [W-1:0] err_evt,
    output logic         irq_o
);
    cfg_t         cfg_q;
    logic [W-1:0] cfg_rdata;
    logic [W-1:0] set_vec;
    logic [W-1:0] clr_vec;
    logic [W-1:0] status_q;
    logic [W-1:0] status_d;
    logic [W-1:0] irq_mask;
    logic         hold;
    lock_state_e  lk_state;

    assign clr_vec = (reg_wr && !reg_addr) ? reg_wdata : '0;

    errcap_cfg_reg #(.W(W), .NID_W(NODE_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (reg_wr && reg_addr),
        .wdata     (reg_wdata),
        .cfg_q     (cfg_q),
        .cfg_rdata (cfg_rdata)
    );

    errcap_evt_filter #(.W(W)) u_filt (
        .evt     (err_evt),
        .cfg     (cfg_q),
        .hold    (hold),
        .set_vec (set_vec)
    );

    errcap_status_reg #(.W(W)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_vec  (set_vec),
        .clr_vec  (clr_vec),
        .hold     (hold),
        .status_q (status_q),
        .status_d (status_d)
    );

    errcap_lock_fsm #(.W(W)) u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .lofe      (cfg_q.lofe),
        .set_vec   (set_vec),
        .next_zero (status_d == '0),
        .hold      (hold),
        .state_q   (lk_state)
    );

    always_comb begin
        irq_mask           = '1;
        irq_mask[ST_CWD]   = ~cfg_q.cwd_irq_off;
        irq_mask[ST_CRD_A] = ~cfg_q.crd_irq_off;
        irq_mask[ST_CRD_B] = ~cfg_q.crd_irq_off;
        irq_o              = |(status_q & irq_mask);
        reg_rdata          = reg_addr ? cfg_rdata : status_q;
    end

    assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (status_q == '0) |-> !irq_o)
        else $error("irq with empty status");

    assert_lkto_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.lkto_off && !status_q[ST_LKTO]) |=> !status_q[ST_LKTO])
        else $error("bank lock timeout recorded while disabled");

    assert_dto_drop_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q.dto_off && !status_q[ST_DTO]) |=> !status_q[ST_DTO])
        else $error("data timeout recorded while disabled");

    assert_reset_open_R1: assert property (@(posedge clk)
        !rst_n |=> (lk_state == LK_OPEN))
        else $error("lock state after reset");

endmodule

// File: tb/bus_err_capture_tb.sv
module bus_err_capture_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        reg_wr;
    logic        reg_addr;
    logic [31:0] reg_wdata;
    logic [31:0] reg_rdata;
    logic [31:0] err_evt;
    logic        irq_o;

    always #5 clk = ~clk;

    bus_err_capture dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .reg_wr    (reg_wr),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .err_evt   (err_evt),
        .irq_o     (irq_o)
    );

    typedef struct {
        logic        addr;
        logic [31:0] val;
        logic        irq;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   n_run  = 0;
    int   n_fail = 0;
    bit   done   = 0;

    // reference state from the requirements
    logic [31:0] m_stat;
    logic [31:0] m_cfg;
    bit          m_lock;

    localparam logic [31:0] IMPL = 32'hFFFF_07FF;
    localparam logic [31:0] SYND = 32'h00F0_0000;
    localparam logic [31:0] CFGM = 32'h8000_00FF;

    function automatic logic m_irq();
        logic [31:0] mk = 32'hFFFF_FFFF;
        if (m_cfg[0]) mk[17] = 1'b0;
        if (m_cfg[1]) begin mk[18] = 1'b0; mk[19] = 1'b0; end
        return |(m_stat & mk);
    endfunction

    task automatic cyc(input logic [31:0] evt, input logic wr, input logic addr,
                       input logic [31:0] wd);
        logic [31:0] eff, setv, clrv, nst;
        logic lofe;
        @(negedge clk); #1;
        err_evt = evt; reg_wr = wr; reg_addr = addr; reg_wdata = wd;
        lofe = m_cfg[31];
        eff = evt & IMPL;
        if (m_cfg[2]) eff[3]  = 1'b0;
        if (m_cfg[3]) eff[31] = 1'b0;
        setv = (m_lock && lofe) ? 32'h0 : eff;
        clrv = (wr && !addr) ? wd : 32'h0;
        nst  = ((m_stat & ~clrv) | setv) & IMPL;
        if (!m_lock) m_lock = lofe && ((setv & ~SYND) != 0);
        else if (!lofe || nst == 0) m_lock = 0;
        m_stat = nst;
        if (wr && addr) m_cfg = wd & CFGM;
    endtask

    task automatic chk(input logic addr, input string tag);
        exp_t e;
        @(negedge clk); #1;
        err_evt = '0; reg_wr = 1'b0; reg_wdata = '0; reg_addr = addr;
        e.addr = addr; e.val = addr ? m_cfg : m_stat; e.irq = m_irq(); e.tag = tag;
        q.push_back(e);
    endtask

    // monitor
    initial begin
        forever begin
            @(negedge clk);
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                n_run++;
                if (reg_rdata !== e.val) begin
                    n_fail++;
                    $display("FAIL %s rdata(addr=%0d) actual=%h expected=%h",
                             e.tag, e.addr, reg_rdata, e.val);
                end
                n_run++;
                if (irq_o !== e.irq) begin
                    n_fail++;
                    $display("FAIL %s irq actual=%0b expected=%0b", e.tag, irq_o, e.irq);
                end
            end
        end
    end

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; reg_wr = 0; reg_addr = 0; reg_wdata = '0; err_evt = '0;
        m_stat = '0; m_cfg = '0; m_lock = 0;
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;

        // R1 reset values
        chk(0, "R1 status");
        chk(1, "R1 cfg");

        // R2 capture, unimplemented gap
        cyc(32'h0001_0001, 0, 0, 0);
        chk(0, "R2 capture");
        cyc(32'h0000_F800, 0, 0, 0);
        chk(0, "R2 gap ignored");

        // R3 write-one-to-clear
        cyc(0, 1, 0, 32'h0000_0001);
        chk(0, "R3 clear one");
        cyc(0, 1, 0, 32'h0000_0000);
        chk(0, "R3 zero write");
        cyc(32'h0000_0020, 1, 0, 32'h0000_0020);
        chk(0, "R3 set beats clear");
        cyc(0, 1, 0, 32'hFFFF_FFFF);
        chk(0, "R3 clear all");

        // R11 / R12 configuration word
        cyc(0, 1, 1, 32'hFFFF_FFFF);
        chk(1, "R11 cfg mask");
        chk(0, "R12 status view");
        cyc(0, 1, 1, 32'h0000_00A0);
        chk(1, "R11 node id");

        // R10 interrupt masking
        cyc(0, 1, 1, 32'h0000_0003);
        cyc(32'h0002_0000, 0, 0, 0);
        chk(0, "R10 cwd masked");
        cyc(32'h000C_0000, 0, 0, 0);
        chk(0, "R10 crd masked");
        cyc(0, 1, 1, 32'h0000_0001);
        chk(0, "R10 crd unmasked");
        cyc(0, 1, 1, 32'h0000_0000);
        chk(0, "R10 all unmasked");
        cyc(0, 1, 0, 32'hFFFF_FFFF);

        // R9 timeout detection off
        cyc(0, 1, 1, 32'h0000_000C);
        cyc(32'h8000_0008, 0, 0, 0);
        chk(0, "R9 timeouts dropped");
        cyc(0, 1, 1, 32'h0000_0000);
        cyc(32'h8000_0008, 0, 0, 0);
        chk(0, "R9 timeouts recorded");
        cyc(0, 1, 0, 32'hFFFF_FFFF);

        // R5 syndrome bits do not lock
        cyc(0, 1, 1, 32'h8000_0000);
        cyc(32'h0010_0000, 0, 0, 0);
        chk(0, "R5 syndrome recorded");
        cyc(32'h0080_0000, 0, 0, 0);
        chk(0, "R5 still open");
        cyc(0, 1, 0, 32'hFFFF_FFFF);

        // R4 lock with simultaneous events
        cyc(32'h0200_0004, 0, 0, 0);
        chk(0, "R4 both captured");
        // R6 discard while locked
        cyc(32'h0000_0080, 0, 0, 0);
        chk(0, "R6 discarded");
        cyc(32'h0040_0000, 1, 0, 32'h0000_0004);
        chk(0, "R6 partial clear only");
        cyc(32'h0000_0080, 0, 0, 0);
        chk(0, "R6 still locked");

        // R7 release by clearing everything
        cyc(0, 1, 0, 32'hFFFF_FFFF);
        cyc(32'h0000_0080, 0, 0, 0);
        chk(0, "R7 recorded after release");
        cyc(32'h0000_0100, 0, 0, 0);
        chk(0, "R7 relocked");

        // R8 release by disabling the lock
        cyc(0, 1, 1, 32'h0000_0000);
        cyc(32'h0000_0200, 0, 0, 0);
        chk(0, "R8 recorded after disable");
        chk(1, "R8 cfg cleared");

        // drain
        repeat (3) @(negedge clk);
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule